// File: doc/BRIEF.md
# Recirculating Serial Shift Register

This block is a one-bit-wide serial delay line of 64 flip-flop stages. On every clock edge where the advance enable is high, each stage takes the value of the stage before it. The first stage loads from one of two serial sources. A low mode select picks the fresh data input. A high mode select picks the recirculate input. That input is usually fed from the block's own true output, so the stored word circulates without loss.

The last stage drives the output in true and inverted polarity. A cascade strobe marks each shift. It is high for the one cycle after every edge that moved the contents. Wiring the strobe to the advance enable of a second instance, and the true output to its data input, chains two instances into a 128-stage line. The downstream half runs one cycle behind the upstream half. A synchronous clear empties every stage so that tests can start from a known state. When the advance enable stays low, the contents stay as they are for as long as needed.

Top module: `recirc_shift_reg`

## Requirements
- R1: After reset is released, all stages read zero: `q_o` is 0, `qn_o` is 1 and `casc_o` is 0.
- R2: On a rising edge with `adv_i`=1, `clr_i`=0 and `mode_i`=0, stage 1 takes `data_i` and every stage k>1 takes the old value of stage k-1.
- R3: On a rising edge with `adv_i`=1, `clr_i`=0 and `mode_i`=1, stage 1 takes `recirc_i`, and the other stages move as in R2. The mode is sampled on the same edge as the data, so a change of mode applies from the next edge.
- R4: On an edge with `adv_i`=0 and `clr_i`=0, no stage changes, whatever `data_i`, `recirc_i` and `mode_i` do.
- R5: `q_o` is stage 64, so a bit that enters stage 1 appears at `q_o` after exactly 64 advancing edges. `qn_o` is always the inverse of `q_o`.
- R6: `casc_o` is 1 in the cycle after an edge where the register shifted, and 0 otherwise.
- R7: `clr_i`=1 on an edge sets all stages to zero. This takes priority over a shift on the same edge, and that edge produces no `casc_o` pulse.
- R8: With `recirc_i` tied to `q_o` and `mode_i`=1, `adv_i`=1, the bit sequence seen on `q_o` repeats unchanged with a period of 64 cycles.
- R9: Two instances chained through `q_o`→`data_i` and `casc_o`→`adv_i` behave as one 128-stage register. With the upstream instance advancing on every edge, the bit driven on `data_i` before the n-th edge appears at the downstream `q_o` after edge n+127.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock; the register acts on rising edges |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| adv_i | input | 1 | Advance enable: shift on this edge |
| clr_i | input | 1 | Synchronous clear of all stages, overrides the shift |
| mode_i | input | 1 | Source select for stage 1: 0 data input, 1 recirculate input |
| data_i | input | 1 | Fresh serial data |
| recirc_i | input | 1 | Recirculation serial input |
| q_o | output | 1 | Last stage, true polarity |
| qn_o | output | 1 | Last stage, inverted polarity |
| casc_o | output | 1 | Cascade strobe, high the cycle after each shift |

## Verification
The clear and the shift can land on the same edge. The bench first fills the register with ones. It then raises `clr_i` on an edge where `adv_i` is high and `data_i` is 1. At the next falling edge it requires `q_o` at 0, `qn_o` at 1 and no cascade strobe. The downstream instance in the chain gets the same clear while its own strobe from the previous shift is still high. A behavioural queue model is compared against both instances on every cycle, and it must still agree after this collision.

// File: rtl/srq_pkg.sv
package srq_pkg;

  // Default number of one-bit stages in a single instance.
  parameter int unsigned SRQ_DEPTH = 64;

  // Which serial source feeds the first stage.
  typedef enum logic {
    SRC_FRESH = 1'b0,
    SRC_LOOP  = 1'b1
  } srq_src_e;

endpackage

// File: rtl/srq_rst_sync.sv
module srq_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_no
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  // Shift a one in from the bottom; the reset is asserted at once and released after STAGES edges.
  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_no = sync_q[STAGES-1];

endmodule

// File: rtl/srq_src_mux.sv
module srq_src_mux
  import srq_pkg::*;
(
  input  logic mode_i,
  input  logic data_i,
  input  logic recirc_i,
  output logic head_o
);

  srq_src_e sel;

  always_comb begin
    sel = srq_src_e'(mode_i);
    unique case (sel)
      SRC_LOOP:  head_o = recirc_i;
      default:   head_o = data_i;
    endcase
  end

endmodule

// File: rtl/srq_stage_chain.sv
module srq_stage_chain #(
  parameter int unsigned DEPTH = 64
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             adv_i,
  input  logic             clr_i,
  input  logic             head_i,
  output logic [DEPTH-1:0] stage_o
);

  localparam int unsigned LAST = DEPTH - 1;

  logic [DEPTH-1:0] stage_q;
  logic [DEPTH-1:0] stage_d;
  logic [DEPTH-1:0] feed;

  // Stage 0 is fed from the source mux, every later stage from its predecessor.
  assign feed = {stage_q[LAST-1:0], head_i};

  // Per-stage next state: clear first, then shift, else hold.
  for (genvar g = 0; g < DEPTH; g++) begin : g_stage
    assign stage_d[g] = clr_i ? 1'b0 : (adv_i ? feed[g] : stage_q[g]);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stage_q <= '0;
    end else begin
      stage_q <= stage_d;
    end
  end

  assign stage_o = stage_q;

endmodule

// File: rtl/srq_cascade.sv
module srq_cascade (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic adv_i,
  input  logic clr_i,
  output logic casc_o
);

  logic casc_q;
  logic casc_d;

  // A shift happened on this edge only when advancing and not clearing.
  always_comb begin
    casc_d = adv_i & ~clr_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      casc_q <= 1'b0;
    end else begin
      casc_q <= casc_d;
    end
  end

  assign casc_o = casc_q;

endmodule

// File: rtl/recirc_shift_reg.sv
module recirc_shift_reg
  import srq_pkg::*;
#(
  parameter int unsigned DEPTH = SRQ_DEPTH
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic adv_i,
  input  logic clr_i,
  input  logic mode_i,
  input  logic data_i,
  input  logic recirc_i,
  output logic q_o,
  output logic qn_o,
  output logic casc_o
);

  localparam int unsigned TAP = DEPTH - 1;

  logic             rst_n_sync;
  logic             head;
  logic [DEPTH-1:0] stage_q;

  srq_rst_sync #(
    .STAGES (2)
  ) u_rst (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .rst_no (rst_n_sync)
  );

  srq_src_mux u_mux (
    .mode_i   (mode_i),
    .data_i   (data_i),
    .recirc_i (recirc_i),
    .head_o   (head)
  );

  srq_stage_chain #(
    .DEPTH (DEPTH)
  ) u_chain (
    .clk_i   (clk_i),
    .rst_ni  (rst_n_sync),
    .adv_i   (adv_i),
    .clr_i   (clr_i),
    .head_i  (head),
    .stage_o (stage_q)
  );

  srq_cascade u_casc (
    .clk_i  (clk_i),
    .rst_ni (rst_n_sync),
    .adv_i  (adv_i),
    .clr_i  (clr_i),
    .casc_o (casc_o)
  );

  // Both polarities are taken straight from the last flop.
  assign q_o  = stage_q[TAP];
  assign qn_o = ~stage_q[TAP];

endmodule

// File: rtl/srq_checker.sv
module srq_checker #(
  parameter int unsigned DEPTH = 64
) (
  input logic             clk_i,
  input logic             rst_n,
  input logic             adv_i,
  input logic             clr_i,
  input logic             mode_i,
  input logic             data_i,
  input logic             recirc_i,
  input logic [DEPTH-1:0] stages,
  input logic             q_o,
  input logic             qn_o,
  input logic             casc_o
);

  assert_head_fresh_R2: assert property (@(posedge clk_i) disable iff (!rst_n)
    (adv_i && !clr_i && !mode_i) |=> (stages[0] == $past(data_i)));

  assert_body_move_R2: assert property (@(posedge clk_i) disable iff (!rst_n)
    (adv_i && !clr_i) |=> (stages[DEPTH-1:1] == $past(stages[DEPTH-2:0])));

  assert_head_loop_R3: assert property (@(posedge clk_i) disable iff (!rst_n)
    (adv_i && !clr_i && mode_i) |=> (stages[0] == $past(recirc_i)));

  assert_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_n)
    (!adv_i && !clr_i) |=> $stable(stages));

  assert_polarity_R5: assert property (@(posedge clk_i) disable iff (!rst_n)
    qn_o != q_o);

  assert_strobe_R6: assert property (@(posedge clk_i) disable iff (!rst_n)
    (adv_i && !clr_i) |=> casc_o);

  assert_strobe_idle_R6: assert property (@(posedge clk_i) disable iff (!rst_n)
    !(adv_i && !clr_i) |=> !casc_o);

  assert_clear_R7: assert property (@(posedge clk_i) disable iff (!rst_n)
    clr_i |=> ((stages == '0) && !q_o && !casc_o));

endmodule

bind recirc_shift_reg srq_checker #(
  .DEPTH (DEPTH)
) chk_i (
  .clk_i    (clk_i),
  .rst_n    (rst_n_sync),
  .adv_i    (adv_i),
  .clr_i    (clr_i),
  .mode_i   (mode_i),
  .data_i   (data_i),
  .recirc_i (recirc_i),
  .stages   (stage_q),
  .q_o      (q_o),
  .qn_o     (qn_o),
  .casc_o   (casc_o)
);

// File: tb/recirc_shift_reg_tb_top.sv
`timescale 1ns/1ps
module recirc_shift_reg_tb_top;

  localparam int unsigned DEPTH = 64;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n, adv, clr, mode, din, rdrv, loop_en;
  logic q_up, qn_up, casc_up, q_dn, qn_dn, casc_dn;
  logic recirc_w;
  bit   cmp_on;
  string phase;
  int tests = 0;
  int fails = 0;

  assign recirc_w = loop_en ? q_up : rdrv;

  recirc_shift_reg #(.DEPTH(DEPTH)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .adv_i(adv), .clr_i(clr), .mode_i(mode),
    .data_i(din), .recirc_i(recirc_w), .q_o(q_up), .qn_o(qn_up), .casc_o(casc_up));

  // Downstream half of a chained pair (R9).
  recirc_shift_reg #(.DEPTH(DEPTH)) dut_b (
    .clk_i(clk), .rst_ni(rst_n), .adv_i(casc_up), .clr_i(clr), .mode_i(1'b0),
    .data_i(q_up), .recirc_i(1'b0), .q_o(q_dn), .qn_o(qn_dn), .casc_o(casc_dn));

  task automatic chk(input string req, input logic act, input logic exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s (phase %s): actual %0b expected %0b", req, phase, act, exp);
    end
  endtask

  // Behavioural reference: index 0 is the entry stage, DEPTH-1 the output stage.
  bit m_up[$];
  bit m_dn[$];
  bit m_casc;

  function automatic void zero_model();
    m_up.delete();
    m_dn.delete();
    repeat (DEPTH) begin
      m_up.push_back(1'b0);
      m_dn.push_back(1'b0);
    end
  endfunction

  initial zero_model();

  always @(posedge clk) begin
    bit up_last, in_bit, up_shift, dn_shift;
    if (!rst_n) begin
      zero_model();
      m_casc = 1'b0;
    end else begin
      up_last  = m_up[DEPTH-1];
      up_shift = adv && !clr;
      dn_shift = m_casc && !clr;
      in_bit   = mode ? (loop_en ? up_last : rdrv) : din;
      if (clr) begin
        zero_model();
      end else begin
        if (dn_shift) begin
          m_dn.push_front(up_last);
          void'(m_dn.pop_back());
        end
        if (up_shift) begin
          m_up.push_front(in_bit);
          void'(m_up.pop_back());
        end
      end
      m_casc = up_shift;
    end
  end

  // Per-cycle comparison against the model, away from the active edge.
  always @(negedge clk) begin
    if (cmp_on) begin
      chk({phase, "/R5 true"}, q_up, m_up[DEPTH-1]);
      chk({phase, "/R5 inverted"}, qn_up, ~m_up[DEPTH-1]);
      chk({phase, "/R6 strobe"}, casc_up, m_casc);
      chk({phase, "/R9 downstream"}, q_dn, m_dn[DEPTH-1]);
    end
  end

  bit pat[DEPTH];
  bit sent[200];
  logic held;

  initial begin
    rst_n = 1'b0; adv = 1'b0; clr = 1'b0; mode = 1'b0;
    din = 1'b0; rdrv = 1'b0; loop_en = 1'b0; cmp_on = 1'b0;
    phase = "R1";
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 q", q_up, 1'b0);
    chk("R1 qn", qn_up, 1'b1);
    chk("R1 strobe", casc_up, 1'b0);
    chk("R1 downstream", q_dn, 1'b0);
    cmp_on = 1'b1;

    phase = "R2";
    repeat (150) begin
      adv = 1'b1; mode = 1'b0; din = 1'($urandom);
      @(negedge clk);
    end

    phase = "R4";
    held = q_up;
    adv = 1'b0;
    repeat (20) begin
      din = 1'($urandom); mode = 1'($urandom); rdrv = 1'($urandom);
      @(negedge clk);
    end
    chk("R4 held output", q_up, held);

    phase = "R2 gapped";
    repeat (120) begin
      adv = 1'($urandom); mode = 1'b0; din = 1'($urandom);
      @(negedge clk);
    end

    phase = "R3";
    repeat (80) begin
      adv = 1'b1; mode = 1'b1; rdrv = 1'($urandom); din = 1'($urandom);
      @(negedge clk);
    end

    phase = "R3 switching";
    for (int i = 0; i < 80; i++) begin
      adv = 1'b1; mode = i[0]; rdrv = 1'($urandom); din = 1'($urandom);
      @(negedge clk);
    end

    // R7: fill with ones, then clear on an edge that would also shift.
    phase = "R7 fill";
    repeat (DEPTH) begin
      adv = 1'b1; mode = 1'b0; din = 1'b1;
      @(negedge clk);
    end
    chk("R7 filled", q_up, 1'b1);
    phase = "R7";
    clr = 1'b1; adv = 1'b1; din = 1'b1;
    @(negedge clk);
    clr = 1'b0; adv = 1'b0;
    chk("R7 cleared q", q_up, 1'b0);
    chk("R7 cleared qn", qn_up, 1'b1);
    chk("R7 no strobe", casc_up, 1'b0);
    repeat (DEPTH + 4) begin
      adv = 1'b1; din = 1'b0;
      @(negedge clk);
      chk("R7 empty after clear", q_up, 1'b0);
    end

    // R8: load a word, then close the loop and watch it come round.
    phase = "R8 load";
    repeat (DEPTH) begin
      adv = 1'b1; mode = 1'b0; din = 1'($urandom);
      @(negedge clk);
    end
    phase = "R8";
    loop_en = 1'b1; mode = 1'b1; adv = 1'b1;
    for (int i = 0; i < DEPTH; i++) begin
      pat[i] = q_up;
      @(negedge clk);
    end
    for (int i = 0; i < 2 * DEPTH; i++) begin
      chk("R8 loop period", q_up, pat[i % DEPTH]);
      @(negedge clk);
    end
    loop_en = 1'b0;

    // R9: clear both, stream continuously, expect 128-edge latency (plus strobe lag).
    phase = "R9";
    clr = 1'b1; adv = 1'b1; mode = 1'b0;
    @(negedge clk);
    clr = 1'b0;
    for (int i = 0; i < 200; i++) begin
      sent[i] = 1'($urandom);
      din = sent[i];
      @(negedge clk);
      if (i >= 127) chk("R9 chained latency", q_dn, sent[i - 127]);
    end

    adv = 1'b0;
    @(negedge clk);
    cmp_on = 1'b0;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #(200000 * 5);
    tests++;
    fails++;
    $display("FAIL watchdog: actual running expected finished");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule